// File: doc/BRIEF.md
# Multi-Queue Single-Read Poll Arbiter

This block answers one poll request by looking at a whole group of receive queues at once. The request carries a bitmask with one bit per queue. Among the queues that are both selected and non-empty, the one with the lowest index wins. Each queue is either a short-message queue or a bulk-message queue, and a parameter map fixes the type of each one.

A short-message winner is popped, and its 64-bit entry is returned. A bulk-message winner is not popped. Instead the block returns a synthesized notification word that carries the queue's index and its producer and consumer pointers. When no selected queue holds data, the block returns a programmable empty word. The queue storage sits outside the block. Each queue is modelled by a non-empty flag, a head-entry data word, a producer pointer, a consumer pointer and a pop strobe.

Requests and responses are both valid/ready streams. A request is accepted only when the single response register is free, or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response stays valid and unchanged until `rsp_ready` is seen high at a clock edge. The mask must stay steady while `req_valid` is high.

Top module: `multi_queue_poll`

## Requirements
- R1: After reset, `rsp_valid` is 0, `q_pop` is all zero and `req_ready` is 1.
- R2: A queue whose mask bit is 0 never wins and is never popped, even when it is non-empty.
- R3: Among the selected non-empty queues, the lowest index wins, whatever the mix of queue types.
- R4: When a short-message queue wins, the response is that queue's head entry with bit 63 forced to 0, and the queue's `q_pop` bit is high for exactly the one accept cycle.
- R5: When a bulk-message queue wins, the response has bit 63 = 1, the queue index in bits [19:16], the producer pointer in bits [15:8], the consumer pointer in bits [7:0] and zeros elsewhere (default widths), and no `q_pop` bit is raised.
- R6: When no selected queue is non-empty, the response equals the `empty_word` input sampled at the accept edge, and no `q_pop` bit is raised.
- R7: The response becomes valid on the edge that accepts the request. While it is unconsumed it stays stable, and `req_ready` stays low.
- R8: `q_pop` is raised only in a cycle where `req_valid` and `req_ready` are both high, at most one bit at a time.
- R9: Bit 63 of every short-message response is 0, even when the stored entry has bit 63 set, so a real short message and a bulk notification can always be told apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Poll request valid |
| req_ready | output | 1 | Poll request accepted when high with valid |
| req_mask | input | NQ | Queues taking part in this poll |
| q_nonempty | input | NQ | Per-queue has-data flag |
| q_data | input | NQ*64 | Head entry of each queue, queue i at [i*64 +: 64] |
| q_prod | input | NQ*PTR_W | Producer pointer of each queue |
| q_cons | input | NQ*PTR_W | Consumer pointer of each queue |
| q_pop | output | NQ | One-cycle dequeue strobe per queue |
| empty_word | input | 64 | Word returned when nothing selected has data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with valid |
| rsp_data | output | 64 | Poll result |

## Verification
The bench mixes masks that hide non-empty low-index queues, so a design that ignored the mask would return the wrong queue or pop one that was never selected. It arranges short and bulk queues next to each other, which exposes an arbiter that pops a bulk queue or lets its type override index priority. Stored entries with bit 63 set catch a design that passes the type bit through unchanged. A back-pressure sequence holds a response while a new request waits, which reveals a design that overwrites the held word or pops a queue early.

// File: rtl/mqp_pkg.sv
package mqp_pkg;
  localparam int WORD_W   = 64;
  localparam int KIND_BIT = WORD_W - 1;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mqp_prio_pick.sv
module mqp_prio_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    any    = |cand;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        idx       = IW'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mqp_word_build.sv
module mqp_word_build
  import mqp_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int IW    = 4
) (
  input  logic             win_any,
  input  logic             win_bulk,
  input  logic [IW-1:0]    win_idx,
  input  word_t            head,
  input  logic [PTR_W-1:0] prod,
  input  logic [PTR_W-1:0] cons,
  input  word_t            empty_word,
  output word_t            word
);
  localparam int PAD_W = WORD_W - 1 - IW - 2 * PTR_W;

  word_t bulk_word;
  word_t short_word;

  assign bulk_word  = {1'b1, {PAD_W{1'b0}}, win_idx, prod, cons};
  assign short_word = head ^ {head[KIND_BIT], {(WORD_W-1){1'b0}}};

  always_comb begin
    if (!win_any)      word = empty_word;
    else if (win_bulk) word = bulk_word;
    else               word = short_word;
  end
endmodule

// File: rtl/multi_queue_poll.sv
module multi_queue_poll
  import mqp_pkg::*;
#(
  parameter int          NQ       = 16,
  parameter int          PTR_W    = 8,
  parameter logic [NQ-1:0] BULK_MAP = 16'hAAAA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [NQ-1:0]       req_mask,
  input  logic [NQ-1:0]       q_nonempty,
  input  logic [NQ*64-1:0]    q_data,
  input  logic [NQ*PTR_W-1:0] q_prod,
  input  logic [NQ*PTR_W-1:0] q_cons,
  output logic [NQ-1:0]       q_pop,
  input  logic [63:0]         empty_word,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [63:0]         rsp_data
);
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;

  word_t            head_arr [NQ];
  logic [PTR_W-1:0] prod_arr [NQ];
  logic [PTR_W-1:0] cons_arr [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_unpack
    assign head_arr[g] = q_data[g*WORD_W +: WORD_W];
    assign prod_arr[g] = q_prod[g*PTR_W +: PTR_W];
    assign cons_arr[g] = q_cons[g*PTR_W +: PTR_W];
  end

  logic          fire;
  logic [NQ-1:0] cand;
  logic          win_any;
  logic [IW-1:0] win_idx;
  logic [NQ-1:0] win_oh;
  logic          win_bulk;
  word_t         result;
  logic          vld_q;
  word_t         data_q;

  assign req_ready = !vld_q || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign cand      = req_mask & q_nonempty;

  mqp_prio_pick #(.N(NQ), .IW(IW)) pick_i (
    .cand   (cand),
    .any    (win_any),
    .idx    (win_idx),
    .onehot (win_oh)
  );

  assign win_bulk = |(win_oh & BULK_MAP);

  mqp_word_build #(.PTR_W(PTR_W), .IW(IW)) build_i (
    .win_any    (win_any),
    .win_bulk   (win_bulk),
    .win_idx    (win_idx),
    .head       (head_arr[win_idx]),
    .prod       (prod_arr[win_idx]),
    .cons       (cons_arr[win_idx]),
    .empty_word (empty_word),
    .word       (result)
  );

  assign q_pop = (fire && !win_bulk) ? (win_oh & ~BULK_MAP) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (fire) begin
      vld_q  <= 1'b1;
      data_q <= result;
    end else if (rsp_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/multi_queue_poll_chk.sv
module multi_queue_poll_chk #(
  parameter int            NQ       = 16,
  parameter logic [NQ-1:0] BULK_MAP = 16'hAAAA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [NQ-1:0] req_mask,
  input logic [NQ-1:0] q_nonempty,
  input logic [NQ-1:0] q_pop,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [63:0]   rsp_data
);
  a_r8_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));
  a_r8_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_pop) |-> (req_valid && req_ready));
  a_r2_pop_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & ~(req_mask & q_nonempty)) == '0);
  a_r5_no_bulk_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & BULK_MAP) == '0);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r7_block_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind multi_queue_poll multi_queue_poll_chk #(.NQ(NQ), .BULK_MAP(BULK_MAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .q_nonempty(q_nonempty), .q_pop(q_pop),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/multi_queue_poll_tb_top.sv
`timescale 1ns/1ps
module multi_queue_poll_tb_top;
  localparam int            NQ    = 16;
  localparam int            PW    = 8;
  localparam logic [NQ-1:0] BULK  = 16'hAAAA;
  localparam int            NV    = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'hFFFF_0000, 32'h0001_0001, 32'h0002_0003, 32'hFFFF_8004, 32'h0F00_0F00,
    32'hF000_A000, 32'h00F0_FF0F, 32'h8000_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0;
  logic [NQ-1:0] req_mask = '0, q_nonempty = '0;
  logic [NQ*64-1:0] q_data;
  logic [NQ*PW-1:0] q_prod, q_cons;
  logic [63:0] empty_word = 64'hE3E3_0000_DEAD_BEEF;
  logic req_ready, rsp_valid;
  logic [NQ-1:0] q_pop;
  logic [63:0] rsp_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  multi_queue_poll #(.NQ(NQ), .PTR_W(PW), .BULK_MAP(BULK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .q_nonempty(q_nonempty), .q_data(q_data),
    .q_prod(q_prod), .q_cons(q_cons), .q_pop(q_pop), .empty_word(empty_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  function automatic logic [63:0] hd(int i);
    return 64'h8123_4500_0000_0000 | (64'(i) * 64'h0101_0101);
  endfunction
  function automatic logic [7:0] pp(int i); return 8'(i * 3 + 1); endfunction
  function automatic logic [7:0] cc(int i); return 8'(200 - i); endfunction

  function automatic logic [63:0] exp_word(logic [NQ-1:0] m, logic [NQ-1:0] ne);
    for (int i = 0; i < NQ; i++)
      if (m[i] && ne[i]) begin
        if (BULK[i]) return {1'b1, 43'b0, 4'(i), pp(i), cc(i)};
        return {1'b0, hd(i)[62:0]};
      end
    return empty_word;
  endfunction
  function automatic logic [NQ-1:0] exp_pop(logic [NQ-1:0] m, logic [NQ-1:0] ne);
    for (int i = 0; i < NQ; i++)
      if (m[i] && ne[i]) return BULK[i] ? '0 : NQ'(1) << i;
    return '0;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poll(logic [NQ-1:0] m, logic [NQ-1:0] ne, string tag);
    logic [63:0] ew;
    logic [NQ-1:0] ep;
    @(negedge clk);
    req_mask = m; q_nonempty = ne; req_valid = 1; rsp_ready = 1;
    ew = exp_word(m, ne); ep = exp_pop(m, ne);
    #1;
    chk(q_pop == ep, {tag, " R4 R5 R6 pop"}, 64'(q_pop), 64'(ep));
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(q_pop == '0, {tag, " R8 pop after accept"}, 64'(q_pop), 64'h0);
    chk(rsp_valid === 1'b1, {tag, " R7 valid"}, 64'(rsp_valid), 64'h1);
    chk(rsp_data == ew, {tag, " R3 word"}, rsp_data, ew);
    chk(rsp_data[63] == (ew != empty_word && exp_pop(m, ne) == '0 ? 1'b1 : ew[63]),
        {tag, " R9 kind"}, 64'(rsp_data[63]), 64'(ew[63]));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      q_data[i*64 +: 64] = hd(i);
      q_prod[i*PW +: PW] = pp(i);
      q_cons[i*PW +: PW] = cc(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(q_pop == 0, "R1 q_pop", 64'(q_pop), 0);
    chk(req_ready == 1, "R1 req_ready", 64'(req_ready), 1);

    for (int v = 0; v < NV; v++)
      poll(VEC[v][31:16], VEC[v][15:0], $sformatf("vec%0d", v));

    // R2: unmasked q0 holds data, masked q3 bulk wins
    poll(16'h0008, 16'h0009, "R2 mask");
    // R6: programmable empty word
    empty_word = 64'h0000_1111_2222_3333;
    poll(16'h0003, 16'h0000, "R6 empty reprogram");
    // R9: short entry with bit63 set returns bit63 clear
    poll(16'h0004, 16'h0004, "R9 short kind");

    // R7/R8 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_mask = 16'h0001; q_nonempty = 16'h0001;
    @(negedge clk);
    req_mask = 16'h0010; q_nonempty = 16'h0010;
    #1;
    chk(req_ready == 0, "R7 req_ready low", 64'(req_ready), 0);
    chk(q_pop == 0, "R8 no pop when blocked", 64'(q_pop), 0);
    chk(rsp_data == {1'b0, hd(0)[62:0]}, "R7 held word", rsp_data, {1'b0, hd(0)[62:0]});
    @(negedge clk);
    #1;
    chk(rsp_data == {1'b0, hd(0)[62:0]}, "R7 stable", rsp_data, {1'b0, hd(0)[62:0]});
    chk(q_pop == 0, "R8 still no pop", 64'(q_pop), 0);
    req_valid = 0;
    @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    #1;
    chk(rsp_valid == 0, "R7 drained", 64'(rsp_valid), 0);
    chk(q_pop == 0, "R8 idle no pop", 64'(q_pop), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule